// File: doc/BRIEF.md
# Ring Buffer Drain Controller

This block sits on the read side of a ring buffer that lives in memory. A separate writer fills the ring, and this block drains it. The ring is described by a base address and a size mask. For each request the block works out how many 16-byte quadwords lie between the drain pointer and the writer pointer, and it counts correctly when the writer has already wrapped past the top. It limits the request to that amount. When the read would run past the top of the ring, it splits the read into two segments. It also returns the drain pointer to use for the next request.

A caller places the ring geometry, the two pointers and a quadword count on the inputs and pulses `req_valid`. One cycle later the block presents the segment addresses and lengths, the next drain address and an empty flag. These outputs hold until the next request. A drain address that lies outside the ring is first folded back into it. The block does no memory access of its own.

The mask must have the form 16·2^k − 16, and the base must be aligned to the ring size (mask + 16). Other settings give undefined results. The writer address is assumed to lie inside the ring.

Top module: `ring_drain_ctrl`

## Requirements
- R1: Out of reset `rsp_valid`, `empty`, `seg0_len` and `seg1_len` are all 0.
- R2: Let `d` be the folded drain address and `w` the writer address. When `d` ≤ `w`, the quadwords available are (`w` − `d`) / 16.
- R3: When `d` > `w`, the quadwords available are ((`w` − base) + (base + mask + 16 − `d`)) / 16. This counts the part of the ring that lies above the drain and also the part from the base up to the writer.
- R4: When no quadwords are available, `empty` is 1 and both segment lengths are 0. This includes the case where the writer address equals the folded drain address. Otherwise `empty` is 0.
- R5: The total transferred, `seg0_len` + `seg1_len`, equals the smaller of the available count and `req_qw`.
- R6: Let room = (base + mask + 16 − `d`) / 16. When the total transferred exceeds room, `seg0_addr` = `d` and `seg0_len` = room. The second segment then has `seg1_addr` = base and `seg1_len` = total − room.
- R7: When the total transferred does not exceed room, `seg0_addr` = `d`, `seg0_len` = total, `seg1_len` = 0 and `seg1_addr` = base.
- R8: `next_drain` = base + ((`d` + 16·total) AND mask). This is always an address inside the ring, and it equals base when the read ends exactly at the top.
- R9: Before any of the above, the drain address is folded as base + (drain AND mask). An address inside the ring is left unchanged, and an address below base or above base + mask is brought into the ring.
- R10: The outputs are updated on the clock edge at which `req_valid` is 1, and `rsp_valid` is 1 for exactly the following cycle. While `req_valid` is 0, every result output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Evaluate a request on this edge |
| ring_base | input | ADDR_W | Ring base address, aligned to ring size |
| ring_mask | input | ADDR_W | Ring size minus 16 |
| wr_addr | input | ADDR_W | Writer's current address |
| drain_addr | input | ADDR_W | Current drain address, may lie outside the ring |
| req_qw | input | CNT_W | Quadwords requested |
| rsp_valid | output | 1 | Result registered on the previous edge |
| seg0_addr | output | ADDR_W | Start address of the first segment |
| seg0_len | output | CNT_W | Quadwords in the first segment |
| seg1_addr | output | ADDR_W | Start address of the second segment (base) |
| seg1_len | output | CNT_W | Quadwords in the second segment, 0 when there is no split |
| next_drain | output | ADDR_W | Drain address after the transfer, inside the ring |
| empty | output | 1 | No quadwords available |

## Verification
The bench uses the default widths, a 32-bit address and a 16-bit count. It varies the ring geometry on every request, with ring sizes from 4 to 256 quadwords placed at many aligned bases. This makes it possible to reach a read that ends exactly at the top of the ring, a request larger than the ring, and a writer sitting just below the drain. Drain addresses are also placed above and below the ring, so the folding path is exercised on both sides.

// File: rtl/ring_drain_pkg.sv
package ring_drain_pkg;
    // log2 of the quadword size in bytes
    localparam int QW_SHIFT = 4;
    localparam int DEF_ADDR_W = 32;
    localparam int DEF_CNT_W  = 16;
endpackage

// File: rtl/ring_occupancy.sv
module ring_occupancy
    import ring_drain_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] mask,
    input  logic [ADDR_W-1:0] wr,
    input  logic [ADDR_W-1:0] drain,
    output logic [ADDR_W-1:0] drain_fold,
    output logic [ADDR_W-1:0] avail,
    output logic [ADDR_W-1:0] room
);
    localparam logic [ADDR_W-1:0] QW_BYTES = ADDR_W'(1) << QW_SHIFT;

    logic [ADDR_W-1:0] top;

    always_comb begin
        top        = base + mask + QW_BYTES;
        drain_fold = base + (drain & mask);
        if (drain_fold <= wr) begin
            avail = (wr - drain_fold) >> QW_SHIFT;
        end else begin
            avail = ((wr - base) + (top - drain_fold)) >> QW_SHIFT;
        end
        room = (top - drain_fold) >> QW_SHIFT;
    end
endmodule

// File: rtl/ring_split.sv
module ring_split
    import ring_drain_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int CNT_W  = DEF_CNT_W
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] mask,
    input  logic [ADDR_W-1:0] drain_fold,
    input  logic [ADDR_W-1:0] avail,
    input  logic [ADDR_W-1:0] room,
    input  logic [CNT_W-1:0]  req,
    output logic [ADDR_W-1:0] s0_addr,
    output logic [CNT_W-1:0]  s0_len,
    output logic [ADDR_W-1:0] s1_addr,
    output logic [CNT_W-1:0]  s1_len,
    output logic [ADDR_W-1:0] nxt,
    output logic              is_empty
);
    logic [CNT_W-1:0]  total;
    logic [ADDR_W-1:0] end_addr;

    always_comb begin
        total    = (avail < ADDR_W'(req)) ? CNT_W'(avail) : req;
        is_empty = (avail == '0);
        s0_addr  = drain_fold;
        s1_addr  = base;
        if (ADDR_W'(total) > room) begin
            s0_len = CNT_W'(room);
            s1_len = total - CNT_W'(room);
        end else begin
            s0_len = total;
            s1_len = '0;
        end
        end_addr = drain_fold + (ADDR_W'(total) << QW_SHIFT);
        nxt      = base + (end_addr & mask);
    end
endmodule

// File: rtl/ring_drain_ctrl.sv
module ring_drain_ctrl
    import ring_drain_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int CNT_W  = DEF_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [ADDR_W-1:0] ring_mask,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ADDR_W-1:0] drain_addr,
    input  logic [CNT_W-1:0]  req_qw,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] seg0_addr,
    output logic [CNT_W-1:0]  seg0_len,
    output logic [ADDR_W-1:0] seg1_addr,
    output logic [CNT_W-1:0]  seg1_len,
    output logic [ADDR_W-1:0] next_drain,
    output logic              empty
);
    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] a0;
        logic [CNT_W-1:0]  l0;
        logic [ADDR_W-1:0] a1;
        logic [CNT_W-1:0]  l1;
        logic [ADDR_W-1:0] nxt;
        logic              emp;
    } rsp_t;

    logic [ADDR_W-1:0] drain_fold, avail, room;
    logic [ADDR_W-1:0] c_a0, c_a1, c_nxt;
    logic [CNT_W-1:0]  c_l0, c_l1;
    logic              c_emp;
    rsp_t              rsp_d, rsp_q;

    ring_occupancy #(.ADDR_W(ADDR_W)) u_occ (
        .base       (ring_base),
        .mask       (ring_mask),
        .wr         (wr_addr),
        .drain      (drain_addr),
        .drain_fold (drain_fold),
        .avail      (avail),
        .room       (room)
    );

    ring_split #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_split (
        .base       (ring_base),
        .mask       (ring_mask),
        .drain_fold (drain_fold),
        .avail      (avail),
        .room       (room),
        .req        (req_qw),
        .s0_addr    (c_a0),
        .s0_len     (c_l0),
        .s1_addr    (c_a1),
        .s1_len     (c_l1),
        .nxt        (c_nxt),
        .is_empty   (c_emp)
    );

    always_comb begin
        rsp_d     = rsp_q;
        rsp_d.vld = req_valid;
        if (req_valid) begin
            rsp_d.a0  = c_a0;
            rsp_d.l0  = c_l0;
            rsp_d.a1  = c_a1;
            rsp_d.l1  = c_l1;
            rsp_d.nxt = c_nxt;
            rsp_d.emp = c_emp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid  = rsp_q.vld;
    assign seg0_addr  = rsp_q.a0;
    assign seg0_len   = rsp_q.l0;
    assign seg1_addr  = rsp_q.a1;
    assign seg1_len   = rsp_q.l1;
    assign next_drain = rsp_q.nxt;
    assign empty      = rsp_q.emp;

    AST_CLAMP_TO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (ADDR_W'(seg0_len) + ADDR_W'(seg1_len) <= ADDR_W'($past(req_qw)))); // R5
    AST_EMPTY_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (seg0_len == '0 && seg1_len == '0)); // R4
    AST_SECOND_AT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (seg1_addr == $past(ring_base))); // R6
    AST_NEXT_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (next_drain >= $past(ring_base) &&
                       next_drain <= $past(ring_base) + $past(ring_mask))); // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(seg0_addr) && $stable(seg0_len) && $stable(seg1_len) &&
                        $stable(next_drain) && $stable(empty) && !rsp_valid)); // R10
endmodule

// File: tb/tb_ring_drain_ctrl.sv
module tb_ring_drain_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] ring_base = '0, ring_mask = '0, wr_addr = '0, drain_addr = '0;
    logic [CW-1:0] req_qw = '0;
    logic          rsp_valid, empty;
    logic [AW-1:0] seg0_addr, seg1_addr, next_drain;
    logic [CW-1:0] seg0_len, seg1_len;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model results
    logic [AW-1:0] e_a0, e_a1, e_nxt;
    logic [CW-1:0] e_l0, e_l1;
    logic          e_emp;

    always #(CLK_PERIOD/2) clk = ~clk;

    ring_drain_ctrl #(.ADDR_W(AW), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .ring_base(ring_base), .ring_mask(ring_mask), .wr_addr(wr_addr),
        .drain_addr(drain_addr), .req_qw(req_qw), .rsp_valid(rsp_valid),
        .seg0_addr(seg0_addr), .seg0_len(seg0_len), .seg1_addr(seg1_addr),
        .seg1_len(seg1_len), .next_drain(next_drain), .empty(empty)
    );

    task automatic chk(input string rq, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Offset arithmetic modulo the ring size
    task automatic model(input logic [AW-1:0] b, input logic [AW-1:0] m,
                         input logic [AW-1:0] w, input logic [AW-1:0] d,
                         input logic [CW-1:0] r);
        longint size, od, ow, av, rm, tot;
        size  = longint'(m) + 16;
        od    = longint'(d) % size;
        ow    = longint'(w) - longint'(b);
        av    = (((ow - od) % size + size) % size) / 16;
        rm    = (size - od) / 16;
        tot   = (av < longint'(r)) ? av : longint'(r);
        e_emp = (av == 0);
        e_a0  = b + AW'(od);
        e_a1  = b;
        if (tot > rm) begin
            e_l0 = CW'(rm);
            e_l1 = CW'(tot - rm);
        end else begin
            e_l0 = CW'(tot);
            e_l1 = '0;
        end
        e_nxt = b + AW'((od + tot * 16) % size);
    endtask

    task automatic run(input string rq, input logic [AW-1:0] b, input logic [AW-1:0] m,
                       input logic [AW-1:0] w, input logic [AW-1:0] d, input logic [CW-1:0] r);
        ring_base = b; ring_mask = m; wr_addr = w; drain_addr = d; req_qw = r;
        req_valid = 1'b1;
        model(b, m, w, d, r);
        @(negedge clk);
        req_valid = 1'b0;
        chk(rq, "rsp_valid R10", rsp_valid, 1);
        chk(rq, "seg0_addr", seg0_addr, e_a0);
        chk(rq, "seg0_len", seg0_len, e_l0);
        chk(rq, "seg1_addr", seg1_addr, e_a1);
        chk(rq, "seg1_len", seg1_len, e_l1);
        chk(rq, "next_drain R8", next_drain, e_nxt);
        chk(rq, "empty R4", empty, e_emp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7219));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "rsp_valid", rsp_valid, 0);
        chk("R1", "empty", empty, 0);
        chk("R1", "seg0_len", seg0_len, 0);
        chk("R1", "seg1_len", seg1_len, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // 16-qw ring at 0x4000, top at 0x4100
        run("R2 R5", 32'h4000, 32'hF0, 32'h4080, 32'h4020, 16'd10);  // 6 available
        run("R2 R5", 32'h4000, 32'hF0, 32'h4080, 32'h4020, 16'd3);   // clamped to 3
        run("R3 R6", 32'h4000, 32'hF0, 32'h4040, 32'h40C0, 16'd20);  // 4 + 4 split
        run("R4", 32'h4000, 32'hF0, 32'h4050, 32'h4050, 16'd5);      // pointers meet
        run("R7 R8", 32'h4000, 32'hF0, 32'h4020, 32'h40E0, 16'd2);   // ends at top
        run("R9", 32'h4000, 32'hF0, 32'h4060, 32'h4230, 16'd16);     // drain above ring
        run("R9", 32'h4000, 32'hF0, 32'h4060, 32'h3F90, 16'd16);     // drain below ring
        run("R4 R9", 32'h4000, 32'hF0, 32'h4030, 32'h4130, 16'd4);   // folds onto writer
        run("R3 R5", 32'h4000, 32'hF0, 32'h40B0, 32'h40C0, 16'hFFFF); // writer just below

        // R10: inputs change with req_valid low, outputs hold
        begin
            logic [AW-1:0] h_a0, h_nxt;
            logic [CW-1:0] h_l0, h_l1;
            logic          h_emp;
            h_a0 = seg0_addr; h_nxt = next_drain; h_l0 = seg0_len; h_l1 = seg1_len; h_emp = empty;
            ring_base = 32'h8000; ring_mask = 32'h3F0; wr_addr = 32'h8100;
            drain_addr = 32'h8010; req_qw = 16'd9;
            repeat (2) @(negedge clk);
            chk("R10", "rsp_valid idle", rsp_valid, 0);
            chk("R10", "seg0_addr hold", seg0_addr, h_a0);
            chk("R10", "seg0_len hold", seg0_len, h_l0);
            chk("R10", "seg1_len hold", seg1_len, h_l1);
            chk("R10", "next_drain hold", next_drain, h_nxt);
            chk("R10", "empty hold", empty, h_emp);
        end

        // Random sweep across geometries and both sides of the wrap point
        for (int i = 0; i < 600; i++) begin
            int unsigned k, nqw, sel;
            logic [AW-1:0] b, m, w, d, size;
            k    = 2 + ($urandom % 7);
            nqw  = 1 << k;
            size = AW'(16) << k;
            m    = size - 16;
            b    = size * AW'(4 + ($urandom % 60));
            w    = b + AW'(16 * ($urandom % nqw));
            d    = b + AW'(16 * ($urandom % nqw));
            sel  = $urandom % 8;
            if (sel == 0) d = d + size * AW'(1 + ($urandom % 3));
            else if (sel == 1) d = d - size * AW'(1 + ($urandom % 3));
            else if (sel == 2) d = w;
            run("R2 R3 R5 R6 R7 R8 R9", b, m, w, d, CW'($urandom % (nqw + nqw / 2 + 1)));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule